// File: doc/BRIEF.md
# Decode-Stage Branch Resolution Unit

This block decides, during instruction decode, whether control flow leaves the sequential path. It looks at the instruction held in the fetch/decode register, together with that register's incremented PC, the two values read from the register file and the result waiting in the execute/memory pipeline register. From these it resolves equal and not-equal conditional branches and the unconditional jump. It then drives the fetch-address select and the flush that clears the fetch/decode register. A redirect therefore costs a single bubble.

Each compare operand passes through its own bypass selector. The selector takes the execute/memory result when that stage will write the register being read. The register file writes in the first half of a cycle and is read in the second half, so no bypass from the memory/writeback stage is needed. The branch target is formed for every instruction, in parallel with the register read. A separate hazard unit decides stalls and supplies a stall input. While that input is high the unit stays silent.

Top module: `id_branch_unit`

## Requirements
- R1: With opcode field instr[31:26] = 6'h04 (equal-branch) and stall low, pc_src is 1 exactly when the two (bypassed) operands are equal, and redirect_pc equals br_target.
- R2: With opcode 6'h05 (not-equal branch) and stall low, pc_src is 1 exactly when the two (bypassed) operands differ, and redirect_pc equals br_target.
- R3: br_target always equals pc4_id plus the sign-extended 16-bit field instr[15:0] shifted left by two, for any opcode and for negative offsets.
- R4: With opcode 6'h02 (jump) and stall low, pc_src is 1 and redirect_pc is {pc4_id[31:28], instr[25:0], 2'b00}.
- R5: Operand A is register instr[25:21] and operand B is register instr[20:16]. Each operand independently takes exm_alu_res instead of the register-file value when exm_wr_en is 1 and exm_rd equals that operand's register number.
- R6: No bypass occurs when exm_rd is 0 or when exm_wr_en is 0. The register-file value is used.
- R7: if_flush always equals pc_src.
- R8: While stall_id is 1, neither pc_src nor if_flush is asserted, whatever the instruction.
- R9: Any opcode other than 6'h02, 6'h04 and 6'h05 (including the all-zero bubble) never asserts pc_src.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| instr_id | input | 32 | Instruction held in the fetch/decode register |
| pc4_id | input | 32 | Incremented PC held in the fetch/decode register |
| rf_rs_data | input | 32 | Register-file read value for instr[25:21] |
| rf_rt_data | input | 32 | Register-file read value for instr[20:16] |
| exm_rd | input | 5 | Destination register in the execute/memory stage |
| exm_wr_en | input | 1 | Execute/memory instruction writes a register |
| exm_alu_res | input | 32 | ALU result in the execute/memory stage |
| stall_id | input | 1 | Decode stall from the hazard unit |
| pc_src | output | 1 | Select redirect_pc as next fetch address |
| if_flush | output | 1 | Clear the fetch/decode register |
| redirect_pc | output | 32 | Branch or jump destination |
| br_target | output | 32 | Branch target, formed for every instruction |

## Verification
The assertions check on every evaluation the invariants that hold for any input. Flush and select always move together. Stall silences both. Opcodes outside the three control-flow codes never redirect. The branch target is always the offset sum, and a jump always goes to its concatenated address. Whether a branch is taken depends on which operand was bypassed, so it is shown by the bench's scenarios: bypass on either side, a blocked bypass from register zero or a non-writing stage, equal against unequal, and the worked case where a taken branch whose incremented PC is 44, with offset 7, lands on 72.

// File: rtl/id_branch_pkg.sv
package id_branch_pkg;
  localparam int XLEN   = 32;
  localparam int REG_AW = 5;
  localparam int OPC_W  = 6;
  localparam int OFF_W  = 16;
  localparam int JIDX_W = 26;

  localparam logic [OPC_W-1:0] OPC_JMP = 6'h02;
  localparam logic [OPC_W-1:0] OPC_BEQ = 6'h04;
  localparam logic [OPC_W-1:0] OPC_BNE = 6'h05;

  typedef enum logic [1:0] {
    CF_NONE = 2'd0,
    CF_BEQ  = 2'd1,
    CF_BNE  = 2'd2,
    CF_JMP  = 2'd3
  } cf_kind_e;

  function automatic cf_kind_e classify(input logic [OPC_W-1:0] opc);
    case (opc)
      OPC_BEQ: return CF_BEQ;
      OPC_BNE: return CF_BNE;
      OPC_JMP: return CF_JMP;
      default: return CF_NONE;
    endcase
  endfunction
endpackage

// File: rtl/br_opnd_bypass.sv
module br_opnd_bypass #(
  parameter int DW = 32,
  parameter int AW = 5
) (
  input  logic [AW-1:0] src_idx,
  input  logic [DW-1:0] rf_val,
  input  logic [AW-1:0] exm_idx,
  input  logic          exm_we,
  input  logic [DW-1:0] exm_val,
  output logic [DW-1:0] opnd,
  output logic          hit
);
  always_comb begin
    hit  = exm_we && (exm_idx != '0) && (exm_idx == src_idx);
    opnd = hit ? exm_val : rf_val;
  end
endmodule

// File: rtl/br_target_calc.sv
module br_target_calc #(
  parameter int DW   = 32,
  parameter int OW   = 16,
  parameter int JW   = 26
) (
  input  logic [DW-1:0] pc4,
  input  logic [OW-1:0] offset,
  input  logic [JW-1:0] jidx,
  output logic [DW-1:0] br_tgt,
  output logic [DW-1:0] jmp_tgt
);
  localparam int EXT_W = DW - OW;
  localparam int HI_W  = DW - JW - 2;

  logic [DW-1:0] off_ext;

  always_comb begin
    off_ext = {{EXT_W{offset[OW-1]}}, offset};
    br_tgt  = pc4 + (off_ext << 2);
    jmp_tgt = {pc4[DW-1 -: HI_W], jidx, 2'b00};
  end
endmodule

// File: rtl/br_decide.sv
module br_decide
  import id_branch_pkg::*;
#(
  parameter int DW = 32
) (
  input  logic [OPC_W-1:0] opc,
  input  logic [DW-1:0]    op_a,
  input  logic [DW-1:0]    op_b,
  input  logic             stall,
  output logic             sel_jump,
  output logic             redirect
);
  cf_kind_e kind;
  logic     same;
  logic     cond_ok;

  always_comb begin
    kind     = classify(opc);
    same     = (op_a == op_b);
    sel_jump = (kind == CF_JMP);
    case (kind)
      CF_BEQ:  cond_ok = same;
      CF_BNE:  cond_ok = !same;
      CF_JMP:  cond_ok = 1'b1;
      default: cond_ok = 1'b0;
    endcase
    redirect = cond_ok && !stall;
  end
endmodule

// File: rtl/id_branch_unit.sv
module id_branch_unit
  import id_branch_pkg::*;
(
  input  logic [XLEN-1:0]   instr_id,
  input  logic [XLEN-1:0]   pc4_id,
  input  logic [XLEN-1:0]   rf_rs_data,
  input  logic [XLEN-1:0]   rf_rt_data,
  input  logic [REG_AW-1:0] exm_rd,
  input  logic              exm_wr_en,
  input  logic [XLEN-1:0]   exm_alu_res,
  input  logic              stall_id,
  output logic              pc_src,
  output logic              if_flush,
  output logic [XLEN-1:0]   redirect_pc,
  output logic [XLEN-1:0]   br_target
);
  localparam int NOPND  = 2;
  localparam int RS_LSB = XLEN - OPC_W - REG_AW;
  localparam int RT_LSB = RS_LSB - REG_AW;

  logic [REG_AW-1:0] src_idx [NOPND];
  logic [XLEN-1:0]   rf_val  [NOPND];
  logic [XLEN-1:0]   opnd    [NOPND];
  logic [NOPND-1:0]  byp_hit;
  logic [XLEN-1:0]   jmp_tgt;
  logic              sel_jump;
  logic              redirect;

  assign src_idx[0] = instr_id[RS_LSB +: REG_AW];
  assign src_idx[1] = instr_id[RT_LSB +: REG_AW];
  assign rf_val[0]  = rf_rs_data;
  assign rf_val[1]  = rf_rt_data;

  for (genvar g = 0; g < NOPND; g++) begin : g_byp
    br_opnd_bypass #(.DW(XLEN), .AW(REG_AW)) u_byp (
      .src_idx (src_idx[g]),
      .rf_val  (rf_val[g]),
      .exm_idx (exm_rd),
      .exm_we  (exm_wr_en),
      .exm_val (exm_alu_res),
      .opnd    (opnd[g]),
      .hit     (byp_hit[g])
    );
  end

  br_target_calc #(.DW(XLEN), .OW(OFF_W), .JW(JIDX_W)) u_tgt (
    .pc4     (pc4_id),
    .offset  (instr_id[OFF_W-1:0]),
    .jidx    (instr_id[JIDX_W-1:0]),
    .br_tgt  (br_target),
    .jmp_tgt (jmp_tgt)
  );

  br_decide #(.DW(XLEN)) u_dec (
    .opc      (instr_id[XLEN-1 -: OPC_W]),
    .op_a     (opnd[0]),
    .op_b     (opnd[1]),
    .stall    (stall_id),
    .sel_jump (sel_jump),
    .redirect (redirect)
  );

  always_comb begin
    pc_src      = redirect;
    if_flush    = redirect;
    redirect_pc = sel_jump ? jmp_tgt : br_target;
  end
endmodule

// File: rtl/id_branch_unit_chk.sv
module id_branch_unit_chk
  import id_branch_pkg::*;
(
  input logic [XLEN-1:0]   instr_id,
  input logic [XLEN-1:0]   pc4_id,
  input logic [XLEN-1:0]   rf_rs_data,
  input logic [XLEN-1:0]   rf_rt_data,
  input logic [REG_AW-1:0] exm_rd,
  input logic              exm_wr_en,
  input logic [XLEN-1:0]   exm_alu_res,
  input logic              stall_id,
  input logic              pc_src,
  input logic              if_flush,
  input logic [XLEN-1:0]   redirect_pc,
  input logic [XLEN-1:0]   br_target
);
  logic [OPC_W-1:0] opc;
  logic             is_cf;

  always_comb begin
    opc   = instr_id[XLEN-1 -: OPC_W];
    is_cf = (opc == OPC_BEQ) || (opc == OPC_BNE) || (opc == OPC_JMP);
    AST_FLUSH_TRACKS_SEL: assert (if_flush == pc_src); // R7
    AST_STALL_SILENT: assert (!(stall_id && (pc_src || if_flush))); // R8
    AST_OTHER_OPC_QUIET: assert (is_cf || !pc_src); // R9
    AST_BR_TARGET_SUM: assert (br_target ==
      pc4_id + ({{(XLEN-OFF_W){instr_id[OFF_W-1]}}, instr_id[OFF_W-1:0]} << 2)); // R3
    AST_JUMP_GOES: assert (!(opc == OPC_JMP && !stall_id) ||
      (pc_src && redirect_pc == {pc4_id[XLEN-1 -: 4], instr_id[JIDX_W-1:0], 2'b00})); // R4
    AST_BRANCH_DEST: assert (!(pc_src && opc != OPC_JMP) || redirect_pc == br_target); // R1
  end
endmodule

bind id_branch_unit id_branch_unit_chk u_chk (.*);

// File: tb/sim_id_branch_unit.sv
module sim_id_branch_unit;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic [31:0] instr_id = '0, pc4_id = '0, rf_rs_data = '0, rf_rt_data = '0;
  logic [4:0]  exm_rd = '0;
  logic        exm_wr_en = 1'b0;
  logic [31:0] exm_alu_res = '0;
  logic        stall_id = 1'b0;
  logic        pc_src, if_flush;
  logic [31:0] redirect_pc, br_target;

  int n_chk = 0;
  int n_fail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  id_branch_unit u0 (.*);

  function automatic logic [31:0] mk_i(input logic [5:0] op, input logic [4:0] rs,
                                       input logic [4:0] rt, input logic [15:0] off);
    return {op, rs, rt, off};
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic drive(input logic [31:0] ins, input logic [31:0] pc4,
                       input logic [31:0] a, input logic [31:0] b,
                       input logic [4:0] rd, input logic we, input logic [31:0] res,
                       input logic st);
    @(posedge clk);
    instr_id = ins; pc4_id = pc4; rf_rs_data = a; rf_rt_data = b;
    exm_rd = rd; exm_wr_en = we; exm_alu_res = res; stall_id = st;
    @(negedge clk);
  endtask

  task automatic t_idle;
    drive('0, 32'd4, '0, '0, '0, 1'b0, '0, 1'b0);
    chk("R9 idle sel", {31'd0, pc_src}, 32'd0);
    chk("R7 idle flush", {31'd0, if_flush}, 32'd0);
  endtask

  task automatic t_beq_taken;
    drive(mk_i(6'h04, 5'd1, 5'd3, 16'd7), 32'd44, 32'd11, 32'd11, 5'd9, 1'b1, 32'd0, 1'b0);
    chk("R1 beq taken sel", {31'd0, pc_src}, 32'd1);
    chk("R7 beq taken flush", {31'd0, if_flush}, 32'd1);
    chk("R1 beq dest 72", redirect_pc, 32'd72);
  endtask

  task automatic t_beq_not;
    drive(mk_i(6'h04, 5'd1, 5'd3, 16'd7), 32'd44, 32'd11, 32'd12, 5'd0, 1'b0, 32'd0, 1'b0);
    chk("R1 beq not taken", {31'd0, pc_src}, 32'd0);
    chk("R7 beq not flush", {31'd0, if_flush}, 32'd0);
  endtask

  task automatic t_bne;
    drive(mk_i(6'h05, 5'd2, 5'd6, 16'd5), 32'd200, 32'd1, 32'd2, 5'd0, 1'b0, 32'd0, 1'b0);
    chk("R2 bne differ taken", {31'd0, pc_src}, 32'd1);
    chk("R2 bne dest", redirect_pc, 32'd220);
    drive(mk_i(6'h05, 5'd2, 5'd6, 16'd5), 32'd200, 32'd7, 32'd7, 5'd0, 1'b0, 32'd0, 1'b0);
    chk("R2 bne equal not taken", {31'd0, pc_src}, 32'd0);
  endtask

  task automatic t_target;
    drive(mk_i(6'h04, 5'd1, 5'd3, 16'hFFFD), 32'd100, 32'd1, 32'd2, 5'd0, 1'b0, 32'd0, 1'b0);
    chk("R3 negative offset", br_target, 32'd88);
    drive(mk_i(6'h23, 5'd1, 5'd3, 16'h0010), 32'h1000, 32'd0, 32'd0, 5'd0, 1'b0, 32'd0, 1'b0);
    chk("R3 target on load", br_target, 32'h1040);
    chk("R9 load no redirect", {31'd0, pc_src}, 32'd0);
  endtask

  task automatic t_jump;
    logic [25:0] idx = 26'h0123456;
    drive({6'h02, idx}, 32'hA000_0010, 32'd3, 32'd4, 5'd0, 1'b0, 32'd0, 1'b0);
    chk("R4 jump sel", {31'd0, pc_src}, 32'd1);
    chk("R4 jump dest", redirect_pc, 32'hA048_D158);
    chk("R7 jump flush", {31'd0, if_flush}, 32'd1);
  endtask

  task automatic t_bypass;
    drive(mk_i(6'h04, 5'd1, 5'd4, 16'd2), 32'd60, 32'd5, 32'd9, 5'd4, 1'b1, 32'd5, 1'b0);
    chk("R5 bypass operand B", {31'd0, pc_src}, 32'd1);
    drive(mk_i(6'h04, 5'd1, 5'd4, 16'd2), 32'd60, 32'd0, 32'd9, 5'd1, 1'b1, 32'd9, 1'b0);
    chk("R5 bypass operand A", {31'd0, pc_src}, 32'd1);
    drive(mk_i(6'h05, 5'd1, 5'd4, 16'd2), 32'd60, 32'd5, 32'd5, 5'd1, 1'b1, 32'd6, 1'b0);
    chk("R5 bypass makes bne taken", {31'd0, pc_src}, 32'd1);
  endtask

  task automatic t_no_bypass;
    drive(mk_i(6'h04, 5'd1, 5'd4, 16'd2), 32'd60, 32'd5, 32'd9, 5'd4, 1'b0, 32'd5, 1'b0);
    chk("R6 no write no bypass", {31'd0, pc_src}, 32'd0);
    drive(mk_i(6'h04, 5'd0, 5'd2, 16'd2), 32'd60, 32'd0, 32'd0, 5'd0, 1'b1, 32'd7, 1'b0);
    chk("R6 reg zero not bypassed", {31'd0, pc_src}, 32'd1);
  endtask

  task automatic t_stall;
    drive(mk_i(6'h04, 5'd1, 5'd3, 16'd7), 32'd44, 32'd8, 32'd8, 5'd0, 1'b0, 32'd0, 1'b1);
    chk("R8 stalled beq sel", {31'd0, pc_src}, 32'd0);
    chk("R8 stalled beq flush", {31'd0, if_flush}, 32'd0);
    drive({6'h02, 26'h3}, 32'd44, 32'd0, 32'd0, 5'd0, 1'b0, 32'd0, 1'b1);
    chk("R8 stalled jump sel", {31'd0, pc_src}, 32'd0);
    drive(mk_i(6'h04, 5'd1, 5'd3, 16'd7), 32'd44, 32'd8, 32'd8, 5'd0, 1'b0, 32'd0, 1'b0);
    chk("R8 released beq sel", {31'd0, pc_src}, 32'd1);
  endtask

  initial begin
    fork
      begin
        t_idle();
        t_beq_taken();
        t_beq_not();
        t_bne();
        t_target();
        t_jump();
        t_bypass();
        t_no_bypass();
        t_stall();
      end
      begin
        repeat (5000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    disable fork;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule